// File: doc/BRIEF.md
# Atomic 16-bit Byte-Bus Timer

A 16-bit up-counter that software reaches through an 8-bit register port. The counter advances on a count-enable input after an optional prescaler, and raises a sticky flag when it wraps from its top value back to zero. Because the counter is wider than the bus, a plain pair of byte accesses can tear: the low byte may roll over between the two reads, or the counter may run with a half-written value between the two writes.

To stop this, the block has a buffered mode, chosen by a control bit. In this mode the high-byte address no longer reaches the live counter. It reaches a shadow byte instead. A read of the low byte copies the live high byte into the shadow, so the high-byte read that follows returns the matching half. A write of the low byte loads the shadow and the written byte into the counter in one cycle, so a 16-bit value lands all at once. With the control bit clear, each byte of the counter is read and written directly.

Top module: `tmr16_atomic`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears the counter, the shadow byte, the prescaler phase, the overflow flag and the control register. After reset all three readable addresses return 0x00.
- R2: Read data is combinational from the address in the same cycle as `busRd`. Address 0 returns the counter low byte. Address 1 returns the high byte (see R4 and R8). Address 2 returns the control byte: bit 0 buffered mode, bits 2:1 prescale select, bit 3 overflow flag, bits 7:4 zero. Address 3, or any cycle with `busRd` low, returns 0x00.
- R3: On each prescaler tick the counter goes up by one. A prescale select of s gives one tick per 2^s enabled cycles (1, 2, 4 or 8), counted from the last prescaler clear.
- R4: In buffered mode, a low-byte read copies the live high byte into the shadow at that clock edge. High-byte reads return the shadow, so the pair stays consistent across a carry into the high byte.
- R5: In buffered mode, a high-byte write changes only the shadow byte. The counter is left alone.
- R6: A low-byte write loads the counter in one cycle. The new value is {shadow, data} in buffered mode and {live high byte, data} in direct mode. A counter write takes priority over an increment in the same cycle, and counting then resumes from the written value.
- R7: A low-byte write clears the prescaler phase. A high-byte write leaves the phase untouched.
- R8: In direct mode, high-byte reads and writes reach the live counter high byte. A direct write also takes priority over an increment. Direct-mode accesses never change the shadow byte; a value left there is still readable after returning to buffered mode.
- R9: An increment from 0xFFFF to 0x0000 sets the overflow flag, which stays set. Writing address 2 with bit 3 at 0 clears it, and writing it with bit 3 at 1 leaves it unchanged. If a wrap and a clear happen in the same cycle, the flag ends set.

Control writes to address 2 take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cntEn | input | 1 | Count enable, fed through the prescaler |
| busAddr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The counter is driven with a steady enable and with gapped enable patterns at all four prescale selects. This separates a divider that counts enabled cycles from one that counts clock cycles, and shows whether a high-byte write disturbs the prescaler phase. Low-byte reads are timed to land just before a carry into the high byte. This shows that the shadow keeps the pre-carry half while the live byte moves on. The same writes and reads are repeated in both modes, which exposes any leak of direct accesses into the shadow. Wraps are placed in the same cycle as a flag-clearing write, and in the same cycle as a low-byte write, to pin down both priority rules.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_LO  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd2;

  // control byte layout
  localparam int CTL_WIDE    = 0;
  localparam int CTL_SEL_LSB = 1;
  localparam int CTL_FLAG    = CTL_SEL_LSB + SEL_W;

  typedef struct packed {
    logic loadLow;    // low-byte write commits a full value
    logic fromBuf;    // high half of that value comes from the shadow
    logic loadHigh;   // direct write of the live high byte
    logic bufWrite;   // shadow takes the bus data
    logic bufLatch;   // shadow takes the live high byte
    logic preClear;   // restart the prescaler phase
    logic flagClear;  // software clear of the overflow flag
  } strobe_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_LOW,
    RD_HIGH_LIVE,
    RD_HIGH_BUF,
    RD_CTL
  } rdsel_t;

endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             countEn,
  input  logic             clear,
  input  logic [SEL_W-1:0] divSel,
  output logic             tick
);

  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] mask;

  // mask has divSel low bits set; a tick fires when those phase bits are all ones
  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(divSel)) mask[i] = 1'b1;
    end
  end

  assign tick = countEn && ((phase & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clear) phase <= '0;
    else if (countEn) phase <= phase + 1'b1;
  end

endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int SEL_W_P = SEL_W,
  parameter int BYTE_W_P = BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busRd,
  input  logic                   busWr,
  input  logic [CTL_FLAG:0]      ctlWdata,
  input  logic                   ovfFlag,
  output strobe_t                stb,
  output rdsel_t                 rdSel,
  output logic [SEL_W_P-1:0]     divSel,
  output logic                   wideMode,
  output logic [BYTE_W_P-1:0]    ctlByte
);

  logic wideQ;
  logic [SEL_W_P-1:0] selQ;
  logic wrLow, wrHigh, wrCtl, rdLow;

  assign wrLow  = busWr && (busAddr == ADDR_LO);
  assign wrHigh = busWr && (busAddr == ADDR_HI);
  assign wrCtl  = busWr && (busAddr == ADDR_CTL);
  assign rdLow  = busRd && (busAddr == ADDR_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      wideQ <= 1'b0;
      selQ  <= '0;
    end else if (wrCtl) begin
      wideQ <= ctlWdata[CTL_WIDE];
      selQ  <= ctlWdata[CTL_SEL_LSB +: SEL_W_P];
    end
  end

  always_comb begin
    stb           = '0;
    stb.loadLow   = wrLow;
    stb.fromBuf   = wideQ;
    stb.loadHigh  = wrHigh && !wideQ;
    stb.bufWrite  = wrHigh && wideQ;
    stb.bufLatch  = rdLow && wideQ;
    stb.preClear  = wrLow;
    stb.flagClear = wrCtl && !ctlWdata[CTL_FLAG];
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (busRd) begin
      unique case (busAddr)
        ADDR_LO:  rdSel = RD_LOW;
        ADDR_HI:  rdSel = wideQ ? RD_HIGH_BUF : RD_HIGH_LIVE;
        ADDR_CTL: rdSel = RD_CTL;
        default:  rdSel = RD_ZERO;
      endcase
    end
  end

  always_comb begin
    ctlByte = '0;
    ctlByte[CTL_WIDE] = wideQ;
    ctlByte[CTL_SEL_LSB +: SEL_W_P] = selQ;
    ctlByte[CTL_FLAG] = ovfFlag;
  end

  assign divSel   = selQ;
  assign wideMode = wideQ;

endmodule

// File: rtl/tmr16_datapath.sv
module tmr16_datapath
  import tmr16_pkg::*;
#(
  parameter int BYTE_W_P = BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    countTick,
  input  strobe_t                 stb,
  input  logic [BYTE_W_P-1:0]     busWdata,
  input  rdsel_t                  rdSel,
  input  logic [BYTE_W_P-1:0]     ctlByte,
  output logic [BYTE_W_P-1:0]     rdData,
  output logic                    ovfFlag,
  output logic [2*BYTE_W_P-1:0]   countVal,
  output logic [BYTE_W_P-1:0]     bufVal
);

  localparam int CNT_W = 2 * BYTE_W_P;

  logic [CNT_W-1:0]    count;
  logic [BYTE_W_P-1:0] hiBuf;
  logic [BYTE_W_P-1:0] liveHigh;
  logic                flag;
  logic                wrapEvent;

  assign liveHigh  = count[CNT_W-1:BYTE_W_P];
  assign wrapEvent = countTick && !stb.loadLow && !stb.loadHigh && (&count);

  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (stb.loadLow)  count <= {(stb.fromBuf ? hiBuf : liveHigh), busWdata};
    else if (stb.loadHigh) count <= {busWdata, count[BYTE_W_P-1:0]};
    else if (countTick)    count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               hiBuf <= '0;
    else if (stb.bufWrite) hiBuf <= busWdata;
    else if (stb.bufLatch) hiBuf <= liveHigh;
  end

  always_ff @(posedge clk) begin
    if (rst)                flag <= 1'b0;
    else if (wrapEvent)     flag <= 1'b1;
    else if (stb.flagClear) flag <= 1'b0;
  end

  always_comb begin
    unique case (rdSel)
      RD_LOW:       rdData = count[BYTE_W_P-1:0];
      RD_HIGH_LIVE: rdData = liveHigh;
      RD_HIGH_BUF:  rdData = hiBuf;
      RD_CTL:       rdData = ctlByte;
      default:      rdData = '0;
    endcase
  end

  assign ovfFlag  = flag;
  assign countVal = count;
  assign bufVal   = hiBuf;

endmodule

// File: rtl/tmr16_atomic.sv
module tmr16_atomic
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cntEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic              ovfFlag
);

  strobe_t             stb;
  rdsel_t              rdSel;
  logic [SEL_W-1:0]    divSel;
  logic                wideMode;
  logic [BYTE_W-1:0]   ctlByte;
  logic                countTick;
  logic [2*BYTE_W-1:0] countVal;
  logic [BYTE_W-1:0]   bufVal;

  tmr16_ctrl #(.SEL_W_P(SEL_W), .BYTE_W_P(BYTE_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .ctlWdata (busWdata[CTL_FLAG:0]),
    .ovfFlag  (ovfFlag),
    .stb      (stb),
    .rdSel    (rdSel),
    .divSel   (divSel),
    .wideMode (wideMode),
    .ctlByte  (ctlByte)
  );

  tmr16_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .countEn (cntEn),
    .clear   (stb.preClear),
    .divSel  (divSel),
    .tick    (countTick)
  );

  tmr16_datapath #(.BYTE_W_P(BYTE_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .countTick (countTick),
    .stb       (stb),
    .busWdata  (busWdata),
    .rdSel     (rdSel),
    .ctlByte   (ctlByte),
    .rdData    (busRdata),
    .ovfFlag   (ovfFlag),
    .countVal  (countVal),
    .bufVal    (bufVal)
  );

endmodule

// File: rtl/tmr16_atomic_chk.sv
module tmr16_atomic_chk
  import tmr16_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busRd,
  input logic                busWr,
  input logic [BYTE_W-1:0]   busWdata,
  input logic [BYTE_W-1:0]   busRdata,
  input logic                ovfFlag,
  input logic                wideMode,
  input logic [2*BYTE_W-1:0] countVal,
  input logic [BYTE_W-1:0]   bufVal
);

  assert_idle_read_R2: assert property (@(posedge clk) disable iff (rst)
    !busRd |-> busRdata == '0);

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    !(busWr && (busAddr == ADDR_LO || (busAddr == ADDR_HI && !wideMode)))
    |=> (countVal == $past(countVal) || countVal == $past(countVal) + 1'b1));

  assert_buf_latch_R4: assert property (@(posedge clk) disable iff (rst)
    (busRd && busAddr == ADDR_LO && wideMode)
    |=> bufVal == $past(countVal[2*BYTE_W-1:BYTE_W]));

  assert_buf_write_R5: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr == ADDR_HI && wideMode) |=> bufVal == $past(busWdata));

  assert_low_commit_R6: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr == ADDR_LO)
    |=> countVal == {($past(wideMode) ? $past(bufVal) : $past(countVal[2*BYTE_W-1:BYTE_W])),
                     $past(busWdata)});

  assert_direct_buf_R8: assert property (@(posedge clk) disable iff (rst)
    !wideMode |=> $stable(bufVal));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovfFlag && !(busWr && busAddr == ADDR_CTL && !busWdata[CTL_FLAG])) |=> ovfFlag);

endmodule

bind tmr16_atomic tmr16_atomic_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busAddr  (busAddr),
  .busRd    (busRd),
  .busWr    (busWr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .ovfFlag  (ovfFlag),
  .wideMode (wideMode),
  .countVal (countVal),
  .bufVal   (bufVal)
);

// File: tb/tb_tmr16_atomic.sv
`timescale 1ns/1ps
module tb_tmr16_atomic;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cntEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = 8'd0;
  wire  [7:0] busRdata;
  wire        ovfFlag;

  always #2.5 clk = ~clk;

  tmr16_atomic dut (
    .clk(clk), .rst(rst), .cntEn(cntEn), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .ovfFlag(ovfFlag)
  );

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int mCnt = 0, mBuf = 0, mPsc = 0, mSel = 0;
  bit mWide = 0, mFlag = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int a, input bit rd, input bit wr, input int d,
                      input bit en, input string req);
    int expRd, mask, nCnt, nBuf;
    bit tick, ovf, wrLo, wrHi, wrCtl, rdLo;
    @(negedge clk);
    busAddr = a[1:0]; busRd = rd; busWr = wr; busWdata = d[7:0]; cntEn = en;
    #1;
    expRd = 0;
    if (rd) begin
      case (a)
        0: expRd = mCnt & 255;
        1: expRd = mWide ? mBuf : (mCnt >> 8);
        2: expRd = (mFlag << 3) | (mSel << 1) | mWide;
        default: expRd = 0;
      endcase
    end
    check(req, "read data", {24'd0, busRdata}, expRd);
    check(req, "overflow flag", {31'd0, ovfFlag}, {31'd0, mFlag});
    @(posedge clk);
    mask  = (1 << mSel) - 1;
    tick  = en && ((mPsc & mask) == mask);
    wrLo  = wr && a == 0;
    wrHi  = wr && a == 1;
    wrCtl = wr && a == 2;
    rdLo  = rd && a == 0;
    ovf   = 0;
    nCnt  = mCnt;
    if (wrLo) nCnt = ((mWide ? mBuf : (mCnt >> 8)) << 8) | d;
    else if (wrHi && !mWide) nCnt = (d << 8) | (mCnt & 255);
    else if (tick) begin
      if (mCnt == 65535) ovf = 1;
      nCnt = (mCnt + 1) & 65535;
    end
    nBuf = mBuf;
    if (mWide && wrHi) nBuf = d;
    else if (mWide && rdLo) nBuf = mCnt >> 8;
    if (wrLo) mPsc = 0;
    else if (en) mPsc = (mPsc + 1) & 7;
    if (ovf) mFlag = 1;
    else if (wrCtl && !d[3]) mFlag = 0;
    if (wrCtl) begin
      mWide = d[0];
      mSel = (d >> 1) & 3;
    end
    mCnt = nCnt;
    mBuf = nBuf;
  endtask

  task automatic rdc(input int a, input bit en, input string req);
    step(a, 1, 0, 0, en, req);
  endtask

  task automatic wrc(input int a, input int d, input bit en, input string req);
    step(a, 0, 1, d, en, req);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state visible at every address
    rdc(0, 0, "R1"); rdc(1, 0, "R1"); rdc(2, 0, "R1");

    // R3: divide by 1, steady and gapped enables
    for (int i = 0; i < 6; i++) rdc(0, 1, "R3");
    for (int i = 0; i < 8; i++) rdc(0, i[0], "R3");
    // R2: unused address and idle read strobe
    rdc(3, 1, "R2");
    step(0, 0, 0, 0, 1, "R2");
    rdc(2, 1, "R2");

    // R3: divide by 2, 4, 8
    wrc(2, 8'h02, 1, "R3");
    for (int i = 0; i < 10; i++) rdc(0, 1, "R3");
    wrc(2, 8'h04, 1, "R3");
    for (int i = 0; i < 14; i++) rdc(0, (i % 3) != 2, "R3");
    wrc(2, 8'h06, 1, "R3");
    for (int i = 0; i < 20; i++) rdc(0, 1, "R3");

    // R7: high write keeps the phase, low write clears it
    for (int i = 0; i < 3; i++) rdc(0, 1, "R7");
    wrc(1, 8'h40, 1, "R7");
    for (int i = 0; i < 8; i++) rdc(0, 1, "R7");
    wrc(0, 8'h10, 1, "R7");
    for (int i = 0; i < 10; i++) rdc(0, 1, "R7");

    // R8: direct high access, shadow preserved across modes
    wrc(2, 8'h00, 0, "R8");
    wrc(1, 8'h7A, 1, "R8");
    rdc(1, 0, "R8");
    wrc(2, 8'h01, 0, "R8");
    wrc(1, 8'h33, 0, "R8");
    wrc(2, 8'h00, 0, "R8");
    rdc(0, 0, "R8");
    rdc(1, 0, "R8");
    wrc(1, 8'h21, 0, "R8");
    rdc(1, 0, "R8");
    wrc(2, 8'h01, 0, "R8");
    rdc(1, 0, "R8");

    // R5: buffered high write touches only the shadow
    wrc(1, 8'h55, 1, "R5");
    rdc(1, 1, "R5");
    rdc(0, 1, "R5");
    step(1, 1, 0, 0, 0, "R5");

    // R4 and R6: atomic write then read across a carry
    wrc(1, 8'h12, 0, "R6");
    wrc(0, 8'hFE, 0, "R6");
    rdc(0, 1, "R4");
    rdc(2, 1, "R4");
    rdc(2, 1, "R4");
    rdc(1, 0, "R4");
    rdc(0, 0, "R4");
    rdc(1, 0, "R4");
    // R6: write wins over an increment in the same cycle
    wrc(0, 8'h80, 1, "R6");
    for (int i = 0; i < 3; i++) rdc(0, 1, "R6");
    wrc(1, 8'h9C, 0, "R6");
    wrc(0, 8'h01, 1, "R6");
    rdc(1, 1, "R6");
    rdc(0, 0, "R6");

    // R9: wrap sets the flag; clear rules
    wrc(1, 8'hFF, 0, "R9");
    wrc(0, 8'hFD, 0, "R9");
    for (int i = 0; i < 5; i++) rdc(2, 1, "R9");
    wrc(2, 8'h09, 0, "R9");
    rdc(2, 0, "R9");
    wrc(2, 8'h01, 0, "R9");
    rdc(2, 0, "R9");
    wrc(1, 8'hFF, 0, "R9");
    wrc(0, 8'hFF, 0, "R9");
    wrc(2, 8'h01, 1, "R9");
    rdc(2, 0, "R9");
    rdc(0, 0, "R9");
    // R9: wrap hidden by a low write leaves the flag clear
    wrc(2, 8'h00, 0, "R9");
    wrc(1, 8'hFF, 0, "R9");
    wrc(0, 8'hFF, 0, "R9");
    wrc(0, 8'h05, 1, "R9");
    rdc(2, 0, "R9");
    wrc(0, 8'hFF, 0, "R9");
    rdc(2, 1, "R9");
    rdc(0, 0, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule